// File: doc/BRIEF.md
# JTAG Padded Scan Sequencer

This block runs one complete instruction-register or data-register scan through a chain of several TAP devices. It is given a scan type, a payload length and a code saying which stable state the TAP is in: Run-Test/Idle, Pause-DR or Pause-IR. From that it produces a fixed TMS entry walk into the matching Shift state. It then clocks out a stream of bits made of three parts: preamble padding for the bypassed devices ahead of the target, the payload, and postamble padding for the devices behind it. It parks the TAP in the Pause state that matches the register type.

TCK runs at half the system clock. TMS and TDI change only when TCK falls, and TDO is sampled when TCK rises. Payload bits come from a bit-serial source, which the block asks for one bit at a time. Only the TDO bits captured during the payload part are passed on to the sink; the padding captures are dropped.

When the scan is done, the block raises a navigation request if the configured stop state for that register type is not the Pause state. A separate navigator then takes the TAP to its final place. The navigator also places the TAP in a supported state before a scan when its state is unknown.

Top module: `jtag_padded_scan`

## Requirements
- R1: After reset, tck, tms, tdi, busy, done, err, nav_req and tdo_valid are all 0.
- R2: Entry TMS values, one per TCK rise, are as follows. DR from Idle (start_code 0) is 1,0,0. DR from Pause-DR or Pause-IR (start_code 1 or 2) is 1,1,1,0,0. IR from Idle is 1,1,0,0. IR from either Pause state is 1,1,1,1,0,0. TDI is 0 during entry.
- R3: After entry, exactly pre_len+scan_len+post_len bits are shifted. The preamble comes first, then the payload, then the postamble. Padding bits are 1. Payload bits are taken from tdi_data one per tdi_take pulse, and the first one taken is the least significant and is shifted first.
- R4: During the shift part, TMS is 0 on every TCK rise except the last shifted bit, where it is 1.
- R5: One more TCK rise with TMS=0 and TDI=0 follows the last shifted bit. A scan therefore has entry+shift+1 rises. When done pulses, tck and tms are 0.
- R6: tdo_valid pulses exactly scan_len times per scan. Each pulse carries the TDO level present at the TCK rise of the matching payload bit, in shift order. Preamble and postamble captures are never reported.
- R7: tms and tdi never change in the same clock in which tck rises.
- R8: A start with scan_len of 0, scan_len above MAX_LEN, or start_code 3 (TAP not in a supported stable state) gives one err pulse. It starts no TCK activity and does not set busy.
- R9: nav_req pulses together with done if, and only if, the stop flag for the scanned register type (ir_stop_pause or dr_stop_pause, latched at start) is 0.
- R10: A start while busy is ignored. The running scan keeps its latched parameters and no err is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan command strobe |
| scan_ir | input | 1 | 1 = instruction register, 0 = data register |
| start_code | input | 2 | Current TAP state: 0 Idle, 1 Pause-DR, 2 Pause-IR, 3 unsupported |
| scan_len | input | LEN_W | Payload bit count |
| pre_len | input | PAD_W | Preamble bit count |
| post_len | input | PAD_W | Postamble bit count |
| dr_stop_pause | input | 1 | DR stop state is Pause-DR |
| ir_stop_pause | input | 1 | IR stop state is Pause-IR |
| tdi_data | input | 1 | Next payload bit from the source |
| tdi_take | output | 1 | Payload bit on tdi_data is consumed at this edge |
| tdo_valid | output | 1 | Captured payload TDO bit is valid |
| tdo_bit | output | 1 | Captured payload TDO bit |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, TAP in matching Pause state |
| err | output | 1 | Command rejected |
| nav_req | output | 1 | Navigator must move the TAP to the stop state |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
A TDO capture for one payload bit and the request for the next payload bit fall in the same system clock. tdo_valid from the previous TCK rise is still high in the clock where the falling edge asks for tdi_data. The bench provokes this with scans that have no padding, and with one-bit payloads surrounded by maximum padding. It drives TDO from a random pattern indexed by rise number and checks the kept captures against the payload window of that pattern. It also checks that the number of bits taken equals scan_len and that every shifted TDI bit matches the expected padded stream.

// File: rtl/jtag_padded_scan.sv
module jtag_padded_scan #(
  parameter int LEN_W   = 11,
  parameter int PAD_W   = 8,
  parameter int MAX_LEN = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan_ir,
  input  logic [1:0]       start_code,
  input  logic [LEN_W-1:0] scan_len,
  input  logic [PAD_W-1:0] pre_len,
  input  logic [PAD_W-1:0] post_len,
  input  logic             dr_stop_pause,
  input  logic             ir_stop_pause,
  input  logic             tdi_data,
  output logic             tdi_take,
  output logic             tdo_valid,
  output logic             tdo_bit,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             nav_req,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo
);
  localparam int CW = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ENTRY, S_SHIFT, S_TAIL} st_t;

  st_t              st, nst;
  logic [CW-1:0]    cnt, ncnt;
  logic             ir_q, paused_q, stop_q;
  logic [LEN_W-1:0] len_q;
  logic [PAD_W-1:0] pre_q, post_q;
  logic [CW-1:0]    total, ones, elen, lo, hi;
  logic             cur_tgt, n_tgt, n_tms, n_tdi, bad, fall;

  assign total = CW'(pre_q) + CW'(len_q) + CW'(post_q);
  assign ones  = CW'(1) + CW'(ir_q) + (paused_q ? CW'(2) : CW'(0));
  assign elen  = ones + CW'(2);
  assign lo    = CW'(pre_q);
  assign hi    = lo + CW'(len_q);
  assign busy  = (st != S_IDLE);
  assign fall  = busy && tck;
  assign bad   = (scan_len == '0) || (scan_len > LEN_W'(MAX_LEN)) || (start_code == 2'd3);
  assign cur_tgt = (st == S_SHIFT) && (cnt >= lo) && (cnt < hi);

  always_comb begin
    nst  = st;
    ncnt = cnt + CW'(1);
    case (st)
      S_ENTRY: if (ncnt == elen)  begin nst = S_SHIFT; ncnt = '0; end
      S_SHIFT: if (ncnt == total) begin nst = S_TAIL;  ncnt = '0; end
      S_TAIL:  begin nst = S_IDLE; ncnt = '0; end
      default: ncnt = '0;
    endcase
  end

  assign n_tgt = (nst == S_SHIFT) && (ncnt >= lo) && (ncnt < hi);
  assign n_tms = (nst == S_ENTRY) ? (ncnt < ones) :
                 (nst == S_SHIFT) ? (ncnt == total - CW'(1)) : 1'b0;
  assign n_tdi = (nst == S_SHIFT) ? (n_tgt ? tdi_data : 1'b1) : 1'b0;
  assign tdi_take = fall && n_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0;
      ir_q <= 1'b0; paused_q <= 1'b0; stop_q <= 1'b1;
      len_q <= '0; pre_q <= '0; post_q <= '0;
      tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0;
      tdo_valid <= 1'b0; tdo_bit <= 1'b0;
      done <= 1'b0; err <= 1'b0; nav_req <= 1'b0;
    end else begin
      tdo_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      nav_req   <= 1'b0;
      if (st == S_IDLE) begin
        if (start && bad) err <= 1'b1;
        else if (start) begin
          st       <= S_ENTRY;
          cnt      <= '0;
          ir_q     <= scan_ir;
          paused_q <= (start_code != 2'd0);
          stop_q   <= scan_ir ? ir_stop_pause : dr_stop_pause;
          len_q    <= scan_len;
          pre_q    <= pre_len;
          post_q   <= post_len;
          tms      <= 1'b1;
          tdi      <= 1'b0;
        end
      end else if (!tck) begin
        tck <= 1'b1;
        if (cur_tgt) begin
          tdo_valid <= 1'b1;
          tdo_bit   <= tdo;
        end
      end else begin
        tck <= 1'b0;
        st  <= nst;
        cnt <= ncnt;
        tms <= n_tms;
        tdi <= n_tdi;
        if (st == S_TAIL) begin
          done    <= 1'b1;
          nav_req <= !stop_q;
        end
      end
    end
  end

  a_r7_pins_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));
  a_r5_done_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tck && !tms && !busy));
  a_r9_nav_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    nav_req |-> done);
  a_r8_err_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  a_r6_capture_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    tdo_valid |-> (busy && tck));
  a_r3_take_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tdi_take |=> !tck);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy || done));
endmodule

// File: tb/jtag_padded_scan_bench.sv
`timescale 1ns/1ps
module jtag_padded_scan_bench;
  localparam int LEN_W = 11;
  localparam int PAD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, scan_ir = 1'b0, dr_stop_pause = 1'b1, ir_stop_pause = 1'b1;
  logic [1:0] start_code = 2'd0;
  logic [LEN_W-1:0] scan_len = '0;
  logic [PAD_W-1:0] pre_len = '0, post_len = '0;
  logic tdi_data, tdi_take, tdo_valid, tdo_bit, busy, done, err, nav_req;
  logic tck, tms, tdi;
  logic tdo = 1'b0;

  jtag_padded_scan #(.LEN_W(LEN_W), .PAD_W(PAD_W), .MAX_LEN(1024)) u_jtag_padded_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_ir(scan_ir), .start_code(start_code),
    .scan_len(scan_len), .pre_len(pre_len), .post_len(post_len),
    .dr_stop_pause(dr_stop_pause), .ir_stop_pause(ir_stop_pause),
    .tdi_data(tdi_data), .tdi_take(tdi_take), .tdo_valid(tdo_valid), .tdo_bit(tdo_bit),
    .busy(busy), .done(done), .err(err), .nav_req(nav_req),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [1023:0] tvec;
  logic [2047:0] pat;
  int tbase = 0;
  int tidx = 0, gidx = 0, rises = 0, err_cnt = 0, r7_bad = 0;
  logic tms_log [4096];
  logic tdi_log [4096];
  logic got_log [2048];
  logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;

  assign tdi_data = tvec[(tidx - tbase) & 1023];

  always @(posedge clk) begin
    if (tdi_take) tidx <= tidx + 1;
    if (tdo_valid) begin got_log[gidx & 2047] <= tdo_bit; gidx <= gidx + 1; end
    if (err) err_cnt <= err_cnt + 1;
  end

  always @(negedge clk) begin
    if (tck && !prev_tck) begin
      tms_log[rises & 4095] = tms;
      tdi_log[rises & 4095] = tdi;
      if (tms !== prev_tms || tdi !== prev_tdi) r7_bad = r7_bad + 1;
      rises = rises + 1;
    end
    if (!tck && prev_tck) tdo = pat[rises & 2047];
    prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_tms(int i, int k, int e, int n);
    if (i < k) return 1'b1;
    if (i < e) return 1'b0;
    if (i < e + n) return (i - e == n - 1);
    return 1'b0;
  endfunction

  function automatic bit exp_tdi(int i, int e, int pre, int len, int n);
    if (i < e || i >= e + n) return 1'b0;
    if (i - e < pre || i - e >= pre + len) return 1'b1;
    return tvec[i - e - pre];
  endfunction

  task automatic run_scan(input bit ir, input int code, input int len, input int pre,
                          input int post, input bit drp, input bit irp, input bit poke);
    int k, e, n, rb, gb, tb, eb, wd;
    bit nav_seen, nav_exp;
    int bad_i;
    k = 1 + int'(ir) + ((code != 0) ? 2 : 0);
    e = k + 2; n = pre + len + post;
    for (int w = 0; w < 32; w++) tvec[w*32 +: 32] = $urandom;
    for (int w = 0; w < 64; w++) pat[w*32 +: 32] = $urandom;
    @(negedge clk);
    rb = rises; gb = gidx; tb = tidx; eb = err_cnt; tbase = tidx;
    tdo = pat[rb & 2047];
    scan_ir = ir; start_code = 2'(code); scan_len = LEN_W'(len);
    pre_len = PAD_W'(pre); post_len = PAD_W'(post);
    dr_stop_pause = drp; ir_stop_pause = irp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      scan_ir = ~ir; scan_len = '0; start_code = 2'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 10000) begin @(negedge clk); wd++; end
    nav_seen = nav_req;
    nav_exp = ir ? !irp : !drp;
    chk(done && !tck && !tms, "R5 parked at done", int'(tck), 0);
    chk(rises - rb == e + n + 1, "R5 rise count", rises - rb, e + n + 1);
    bad_i = -1;
    for (int i = 0; i < e; i++)
      if (bad_i < 0 && tms_log[(rb + i) & 4095] !== exp_tms(i, k, e, n)) bad_i = i;
    chk(bad_i < 0, "R2 entry tms", bad_i, -1);
    bad_i = -1;
    for (int i = e; i < e + n + 1; i++)
      if (bad_i < 0 && tms_log[(rb + i) & 4095] !== exp_tms(i, k, e, n)) bad_i = i;
    chk(bad_i < 0, "R4 shift/tail tms", bad_i, -1);
    bad_i = -1;
    for (int i = 0; i < e + n + 1; i++)
      if (bad_i < 0 && tdi_log[(rb + i) & 4095] !== exp_tdi(i, e, pre, len, n)) bad_i = i;
    chk(bad_i < 0, "R3 tdi stream", bad_i, -1);
    chk(tidx - tb == len, "R3 bits taken", tidx - tb, len);
    chk(gidx - gb == len, "R6 capture count", gidx - gb, len);
    bad_i = -1;
    for (int b = 0; b < len; b++)
      if (bad_i < 0 && got_log[(gb + b) & 2047] !== pat[(rb + e + pre + b) & 2047]) bad_i = b;
    chk(bad_i < 0, "R6 captured payload", bad_i, -1);
    chk(nav_seen == nav_exp, "R9 nav request", int'(nav_seen), int'(nav_exp));
    if (poke) chk(err_cnt == eb, "R10 start while busy ignored", err_cnt - eb, 0);
    @(negedge clk);
  endtask

  task automatic bad_cmd(input int len, input int code);
    int rb, eb;
    @(negedge clk);
    rb = rises; eb = err_cnt;
    scan_len = LEN_W'(len); start_code = 2'(code); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(err_cnt - eb == 1 && rises == rb && !busy, "R8 rejected command", err_cnt - eb, 1);
  endtask

  task automatic finish_run;
    chk(r7_bad == 0, "R7 pins stable at rise", r7_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8ns * 190000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(!tck && !tms && !tdi && !busy && !done && !err && !nav_req && !tdo_valid,
        "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_scan(1'b0, 0, 8, 0, 0, 1'b1, 1'b1, 1'b0);
    run_scan(1'b0, 1, 5, 2, 3, 1'b0, 1'b1, 1'b0);
    run_scan(1'b1, 0, 4, 1, 1, 1'b1, 1'b0, 1'b0);
    run_scan(1'b1, 2, 6, 3, 0, 1'b1, 1'b1, 1'b0);
    run_scan(1'b0, 0, 1, 0, 0, 1'b1, 1'b1, 1'b0);
    run_scan(1'b1, 1, 1, 255, 255, 1'b0, 1'b0, 1'b0);
    run_scan(1'b0, 2, 1024, 255, 255, 1'b1, 1'b0, 1'b0);
    run_scan(1'b0, 0, 40, 2, 2, 1'b1, 1'b1, 1'b1);
    bad_cmd(0, 0);
    bad_cmd(1025, 1);
    bad_cmd(8, 3);
    for (int t = 0; t < 30; t++)
      run_scan(1'($urandom % 2), int'($urandom % 3), 1 + int'($urandom % 64),
               int'($urandom % 9), int'($urandom % 9), 1'($urandom % 2), 1'($urandom % 2),
               1'($urandom % 4 == 0));
    finish_run();
  end
endmodule